// File: doc/BRIEF.md
# Filtered Event Counter Pair

This block is one performance-monitor counter with its own control register, built for placement inside a monitored unit. Each cycle the unit presents an event code and a vector of small increments, one per subevent source. The control register chooses which event code is counted, which subevents are summed, and how that sum is turned into a count step. The step can be the raw sum, a single step when the sum passes a threshold (or, inverted, when it stays below it), or a single step on each rising edge of that qualified condition. A box-level control word adds freezing and a clear command.

The 48-bit count can be read at any time through a small register port and keeps counting while it is read. Software may also preset either half of the count, for example to place it just below the wrap point.

Register map (word address on `reg_addr`): 0 = control, 1 = box control, 2 = count bits 31:0, 3 = count bits 47:32 (upper 16 read bits are zero).

Top module: `evt_counter_pair`

## Requirements
- R1: The count is 48 bits wide. An advance that carries out of bit 47 wraps it through zero, and counting continues from the wrapped value.
- R2: With threshold (control bits 31:24) zero, each qualifying cycle adds the sum of the 6-bit subevent increments whose mask bit is set; mask bit i is control bit 8+i and selects subevent i, found at `sub_inc[6i+5:6i]`. Increments up to 32 per subevent are summed without loss.
- R3: With a non-zero threshold, a qualifying cycle adds exactly one when the masked sum is greater than or equal to the threshold. With the invert bit (control bit 17) set, it adds one when the sum is less than the threshold instead. Invert has no effect when the threshold is zero.
- R4: With the edge bit (control bit 16) set, the count advances by one only in a cycle where the qualified condition holds and did not hold in the previous cycle. The condition is the threshold result, or a non-zero masked sum when the threshold is zero.
- R5: The count does not change when the enable bit (control bit 18) is clear, or when `ev_code` differs from the event select in control bits 7:0.
- R6: When freeze-enable (box bit 16) is set, either the box freeze bit (box bit 8) or the `frz_in` input holds the count. With freeze-enable clear, both are ignored.
- R7: Writing the value 2 to box bits 1:0 clears the count in that cycle, taking priority over any advance. Other values of these bits do not clear it, and they always read back as zero.
- R8: Reading address 2 or 3 returns the current count without stopping it. A write to address 2 or 3 loads that half, and in that cycle the write replaces the advance.
- R9: After reset, the control word, box word and count all read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_code | input | 8 | Code of the event the unit presents this cycle |
| sub_inc | input | 48 | Eight 6-bit subevent increments, subevent i at bits 6i+5:6i |
| frz_in | input | 1 | External freeze request |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from the addressed register |

## Verification
Every internal fault in this block surfaces as a wrong count value, and it can be seen on the read port one clock after the cycle that went wrong. A bad masked sum or threshold compare gives a count delta that differs from the expected sum, or from a single step. A stale or mistimed edge register gives extra counts across several consecutive true cycles. A freeze or clear that decodes the wrong field shows as a count that moves or is lost after the window in which it should have been held. The bench reads the count after each short stimulus window, so it can report which window went wrong.

// File: rtl/evt_counter_pair.sv
module evt_counter_pair #(
  parameter int NSUB = 8,
  parameter int INCW = 6,
  parameter int CW   = 48,
  parameter int THRW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [7:0]           ev_code,
  input  logic [NSUB*INCW-1:0] sub_inc,
  input  logic                 frz_in,
  input  logic                 reg_wr,
  input  logic [1:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata
);
  localparam int SUMW    = INCW + $clog2(NSUB);
  localparam int CMPW    = (SUMW > THRW) ? SUMW : THRW;
  localparam int SUM_MAX = NSUB * ((1 << INCW) - 1);
  localparam int HIW     = CW - 32;

  logic [31:0]     ctl_q;
  logic            frz_q, frz_en_q;
  logic [CW-1:0]   cnt_q;
  logic            hit_q;

  logic [SUMW-1:0] sum;
  logic [CMPW-1:0] sum_w, thr_w;
  logic [NSUB-1:0] mask;
  logic [THRW-1:0] thr;
  logic            sel_ok, thr_nz, ge, hit, frozen, adv, edge_en, inv, en;
  logic [SUMW-1:0] step;
  logic            wr_ctl, wr_box, wr_lo, wr_hi, clr;

  assign mask    = ctl_q[8 +: NSUB];
  assign thr     = ctl_q[31 -: THRW];
  assign edge_en = ctl_q[16];
  assign inv     = ctl_q[17];
  assign en      = ctl_q[18];
  assign sel_ok  = ev_code == ctl_q[7:0];
  assign thr_nz  = |thr;

  always_comb begin
    sum = '0;
    for (int i = 0; i < NSUB; i++)
      if (mask[i]) sum = sum + SUMW'(sub_inc[i*INCW +: INCW]);
  end

  assign sum_w  = CMPW'(sum);
  assign thr_w  = CMPW'(thr);
  assign ge     = sum_w >= thr_w;
  assign hit    = sel_ok && (thr_nz ? (inv ? !ge : ge) : (sum != '0));
  assign frozen = frz_en_q && (frz_q || frz_in);
  assign adv    = en && !frozen;

  always_comb begin
    if (edge_en)      step = SUMW'(hit && !hit_q);
    else if (thr_nz)  step = SUMW'(hit);
    else if (sel_ok)  step = sum;
    else              step = '0;
  end

  assign wr_ctl = reg_wr && reg_addr == 2'd0;
  assign wr_box = reg_wr && reg_addr == 2'd1;
  assign wr_lo  = reg_wr && reg_addr == 2'd2;
  assign wr_hi  = reg_wr && reg_addr == 2'd3;
  assign clr    = wr_box && reg_wdata[1:0] == 2'b10;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      frz_q    <= 1'b0;
      frz_en_q <= 1'b0;
      hit_q    <= 1'b0;
    end else begin
      hit_q <= hit;
      if (wr_ctl) ctl_q <= reg_wdata;
      if (wr_box) begin
        frz_q    <= reg_wdata[8];
        frz_en_q <= reg_wdata[16];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (wr_lo)  cnt_q[31:0] <= reg_wdata;
    else if (wr_hi)  cnt_q[CW-1:32] <= reg_wdata[HIW-1:0];
    else if (adv)    cnt_q <= cnt_q + CW'(step);
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = ctl_q;
      2'd1:    reg_rdata = {15'd0, frz_en_q, 7'd0, frz_q, 8'd0};
      2'd2:    reg_rdata = cnt_q[31:0];
      default: reg_rdata = 32'(cnt_q[CW-1:32]);
    endcase
  end

  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((&cnt_q) && adv && step != '0 && !reg_wr) |=> cnt_q < CW'(SUM_MAX));

  p_step_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !reg_wr) |=> (cnt_q - $past(cnt_q)) <= CW'(SUM_MAX));

  p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !reg_wr && (thr_nz || edge_en)) |=> (cnt_q - $past(cnt_q)) <= CW'(1));

  p_edge_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !reg_wr && edge_en && hit_q) |=> $stable(cnt_q));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((!en || ev_code != ctl_q[7:0]) && !reg_wr) |=> $stable(cnt_q));

  p_freeze_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !reg_wr) |=> $stable(cnt_q));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);
endmodule

// File: tb/tb_evt_counter_pair.sv
`timescale 1ns/100ps
module tb_evt_counter_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ev_code = 8'hFF;
  logic [47:0] sub_inc = '0;
  logic        frz_in = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  evt_counter_pair dut (
    .clk(clk), .rst_n(rst_n), .ev_code(ev_code), .sub_inc(sub_inc),
    .frz_in(frz_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  localparam logic [47:0] ONES = {8{6'd1}};
  localparam logic [47:0] SEQ  = {6'd8, 6'd7, 6'd6, 6'd5, 6'd4, 6'd3, 6'd2, 6'd1};
  localparam logic [47:0] BIG  = {8{6'd32}};

  typedef struct packed {
    logic [7:0]  ev;
    logic [47:0] sub;
    logic [31:0] ctl;
    logic [3:0]  n;
    logic [11:0] exp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{8'h11, ONES, 32'h0004_FF11, 4'd1, 12'd8},    // R2 all subevents
    '{8'h11, SEQ,  32'h0004_0511, 4'd2, 12'd8},    // R2 mask picks 0 and 2
    '{8'h11, BIG,  32'h0004_FF11, 4'd1, 12'd256},  // R2 largest increments
    '{8'h11, SEQ,  32'h0A04_FF11, 4'd3, 12'd3},    // R3 sum 36 >= 10
    '{8'h11, SEQ,  32'h2804_FF11, 4'd3, 12'd0},    // R3 sum 36 < 40
    '{8'h11, SEQ,  32'h2806_FF11, 4'd3, 12'd3},    // R3 inverted
    '{8'h11, SEQ,  32'h2404_FF11, 4'd1, 12'd1},    // R3 equal boundary
    '{8'h11, SEQ,  32'h2406_FF11, 4'd1, 12'd0},    // R3 inverted equal
    '{8'h11, SEQ,  32'h0005_FF11, 4'd4, 12'd1},    // R4 edge, raw
    '{8'h11, SEQ,  32'h0A05_FF11, 4'd4, 12'd1},    // R4 edge, threshold
    '{8'h11, SEQ,  32'h0000_FF11, 4'd2, 12'd0},    // R5 disabled
    '{8'h11, SEQ,  32'h0004_FF22, 4'd2, 12'd0},    // R5 code mismatch
    '{8'h11, SEQ,  32'h0006_FF11, 4'd1, 12'd36}    // R3 invert at zero threshold
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic drive(input logic [47:0] s, input int n);
    ev_code = 8'h11; sub_inc = s;
    repeat (n) @(negedge clk);
    ev_code = 8'hFF; sub_inc = '0;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d); chk("R9 reset value", d, 32'h0);
    end

    for (int i = 0; i < NV; i++) begin
      wr(2'd1, 32'h2);
      wr(2'd0, VEC[i].ctl);
      ev_code = VEC[i].ev; sub_inc = VEC[i].sub;
      repeat (int'(VEC[i].n)) @(negedge clk);
      ev_code = 8'hFF; sub_inc = '0;
      rd(2'd2, d); chk($sformatf("R2/R3/R4/R5 vector %0d low", i), d, 32'(VEC[i].exp));
      rd(2'd3, d); chk($sformatf("R1 vector %0d high", i), d, 32'h0);
    end

    // R1 wrap
    wr(2'd0, 32'h0004_0111);
    wr(2'd3, 32'h0000_FFFF);
    wr(2'd2, 32'hFFFF_FFFE);
    rd(2'd3, d); chk("R8 preset high", d, 32'h0000_FFFF);
    drive(ONES, 3);
    rd(2'd2, d); chk("R1 wrap low", d, 32'h1);
    rd(2'd3, d); chk("R1 wrap high", d, 32'h0);

    // R8 read while counting, write replaces advance
    wr(2'd1, 32'h2);
    ev_code = 8'h11; sub_inc = ONES;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      rd(2'd2, d); chk("R8 live read", d, 32'(k));
    end
    wr(2'd2, 32'd100);
    rd(2'd2, d); chk("R8 write wins", d, 32'd100);
    @(negedge clk);
    rd(2'd2, d); chk("R8 count resumes", d, 32'd101);
    ev_code = 8'hFF; sub_inc = '0;

    // R6 freeze
    wr(2'd1, 32'h2);
    wr(2'd1, 32'h0000_0100);
    drive(ONES, 2);
    rd(2'd2, d); chk("R6 freeze bit without enable", d, 32'd2);
    wr(2'd1, 32'h0001_0100);
    drive(ONES, 2);
    rd(2'd2, d); chk("R6 freeze bit with enable", d, 32'd2);
    wr(2'd1, 32'h0001_0000);
    frz_in = 1'b1;
    drive(ONES, 2);
    rd(2'd2, d); chk("R6 external freeze with enable", d, 32'd2);
    wr(2'd1, 32'h0);
    drive(ONES, 2);
    rd(2'd2, d); chk("R6 external freeze without enable", d, 32'd4);
    frz_in = 1'b0;
    wr(2'd1, 32'h0001_0000);
    drive(ONES, 2);
    rd(2'd2, d); chk("R6 enable only, no freeze", d, 32'd6);
    rd(2'd1, d); chk("R6 box readback", d, 32'h0001_0000);

    // R7 clear command decode
    wr(2'd1, 32'h1);
    rd(2'd2, d); chk("R7 value 1 keeps count", d, 32'd6);
    wr(2'd1, 32'h3);
    rd(2'd2, d); chk("R7 value 3 keeps count", d, 32'd6);
    rd(2'd1, d); chk("R7 command bits read zero", d, 32'h0);
    ev_code = 8'h11; sub_inc = ONES;
    wr(2'd1, 32'h2);
    ev_code = 8'hFF; sub_inc = '0;
    rd(2'd2, d); chk("R7 clear beats advance", d, 32'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule